// File: doc/BRIEF.md
# Hybrid Tagged/Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Every entry in both of its tables is a 2-bit saturating counter. The first table is small and tagged, so it follows individual branches exactly. The second table is larger and has no tags. It is indexed directly by the low address bits, so two branches that share those bits also share a counter. On the fetch side, the block takes the branch word address and returns two signals in the same cycle: a taken/not-taken prediction and a flag that says whether the tagged table hit.

On the resolve side, the block takes the address of a resolved branch and its real outcome. It then trains the counter that made the prediction for that branch. When the tagged table hits, its counter predicts and is the one trained. When it misses, the untagged counter predicts and is trained, and the tagged slot is taken over for the missing branch. Addresses are word addresses: the two byte-offset bits of the PC are removed before they reach the block.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset every counter holds 01 and every tagged slot is invalid, so any lookup returns lk_hit=0 and lk_taken=0.
- R2: The prediction is the most significant bit of the selected counter: states 10 and 11 mean taken, states 00 and 01 mean not-taken.
- R3: The tagged slot is chosen by the low T_IDX_W bits of the word address. The tag is all the remaining upper bits. A hit requires a valid slot whose stored tag equals the address's upper bits.
- R4: The untagged table is chosen by the low B_IDX_W bits of the word address (B_IDX_W > T_IDX_W). Addresses that agree in those bits share one counter.
- R5: On a tagged hit the tagged counter supplies the prediction. On a miss the untagged counter supplies it.
- R6: Training with taken adds one to the counter, stopping at 11. Training with not-taken subtracts one, stopping at 00.
- R7: Training that hits the tagged table changes only that tagged counter. The untagged counter is left as it was.
- R8: Training that misses updates the untagged counter. It also fills the tagged slot: valid is set, the new tag is written, and the counter is set to the untagged counter's value after the update, replacing any previous occupant.
- R9: A lookup and a training to the same entry in the same cycle are both allowed. The lookup returns the value before the update, and the new value shows from the next cycle.
- R10: State changes only when tr_en is high. Valid bits are never cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | PC_W-2 | Fetch branch word address |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | Tagged table hit for lk_addr |
| tr_en | input | 1 | Training strobe |
| tr_addr | input | PC_W-2 | Resolved branch word address |
| tr_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach is the one that proves a hit leaves the untagged counter alone. The only route to that counter is a second address that shares its untagged index but misses the tagged table. The stimulus first trains one address until it hits, several times over. It then looks up a different address that uses the same tagged slot with a different tag, and so reads the shared untagged counter directly. Eviction and aliasing are reached the same way, using address pairs chosen to collide in one table while staying distinct in the other.

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred #(
  parameter int PC_W    = 32,
  parameter int T_IDX_W = 4,
  parameter int B_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-3:0] lk_addr,
  output logic            lk_taken,
  output logic            lk_hit,
  input  logic            tr_en,
  input  logic [PC_W-3:0] tr_addr,
  input  logic            tr_taken
);
  localparam int AW    = PC_W - 2;
  localparam int T_N   = 1 << T_IDX_W;
  localparam int B_N   = 1 << B_IDX_W;
  localparam int TAG_W = AW - T_IDX_W;

  logic [1:0]       tcnt [T_N];
  logic [TAG_W-1:0] ttag [T_N];
  logic [T_N-1:0]   tval;
  logic [1:0]       bcnt [B_N];

  function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  logic [T_IDX_W-1:0] lk_ti, tr_ti;
  logic [B_IDX_W-1:0] lk_bi, tr_bi;
  logic [TAG_W-1:0]   lk_tg, tr_tg;
  logic [1:0]         lk_ctr, tr_tnx, tr_bnx;
  logic               tr_hit;

  assign lk_ti = lk_addr[T_IDX_W-1:0];
  assign lk_bi = lk_addr[B_IDX_W-1:0];
  assign lk_tg = lk_addr[AW-1:T_IDX_W];
  assign tr_ti = tr_addr[T_IDX_W-1:0];
  assign tr_bi = tr_addr[B_IDX_W-1:0];
  assign tr_tg = tr_addr[AW-1:T_IDX_W];

  assign lk_hit   = tval[lk_ti] && (ttag[lk_ti] == lk_tg);
  assign lk_ctr   = lk_hit ? tcnt[lk_ti] : bcnt[lk_bi];
  assign lk_taken = lk_ctr[1];

  assign tr_hit = tval[tr_ti] && (ttag[tr_ti] == tr_tg);
  assign tr_tnx = sat_step(tcnt[tr_ti], tr_taken);
  assign tr_bnx = sat_step(bcnt[tr_bi], tr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tval <= '0;
      for (int i = 0; i < T_N; i++) begin
        tcnt[i] <= 2'b01;
        ttag[i] <= '0;
      end
      for (int i = 0; i < B_N; i++) bcnt[i] <= 2'b01;
    end else if (tr_en) begin
      if (tr_hit) begin
        tcnt[tr_ti] <= tr_tnx;
      end else begin
        bcnt[tr_bi] <= tr_bnx;
        tcnt[tr_ti] <= tr_bnx;
        ttag[tr_ti] <= tr_tg;
        tval[tr_ti] <= 1'b1;
      end
    end
  end
endmodule

module hybrid_dir_pred_chk #(
  parameter int PC_W    = 32,
  parameter int T_IDX_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PC_W-3:0]       lk_addr,
  input logic                  lk_taken,
  input logic                  lk_hit,
  input logic                  tr_en,
  input logic [PC_W-3:0]       tr_addr,
  input logic                  tr_taken,
  input logic [(1<<T_IDX_W)-1:0] tval
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!lk_hit && tval == '0));

  // R8
  alloc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && tr_addr == lk_addr) |=> ($stable(lk_addr) -> lk_hit));

  // R6
  train_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && tr_taken && tr_addr == lk_addr && lk_taken) |=> ($stable(lk_addr) -> lk_taken));

  // R6
  train_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && !tr_taken && tr_addr == lk_addr && !lk_taken) |=> ($stable(lk_addr) -> !lk_taken));

  // R10
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(tval) & ~tval) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_en |=> $stable(tval));
endmodule

bind hybrid_dir_pred hybrid_dir_pred_chk #(.PC_W(PC_W), .T_IDX_W(T_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken), .lk_hit(lk_hit),
  .tr_en(tr_en), .tr_addr(tr_addr), .tr_taken(tr_taken), .tval(tval)
);

// File: tb/hybrid_dir_pred_bench.sv
module hybrid_dir_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] lk_addr = '0;
  logic        lk_taken, lk_hit;
  logic        tr_en = 1'b0;
  logic [29:0] tr_addr = '0;
  logic        tr_taken = 1'b0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  hybrid_dir_pred u_hybrid_dir_pred (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken), .lk_hit(lk_hit),
    .tr_en(tr_en), .tr_addr(tr_addr), .tr_taken(tr_taken)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [29:0] a, logic exp_t, logic exp_h);
    lk_addr = a;
    #1;
    n_run++;
    if (lk_taken !== exp_t || lk_hit !== exp_h) begin
      n_fail++;
      $display("FAIL %s addr=%h taken/hit actual=%b%b expected=%b%b", req, a, lk_taken, lk_hit, exp_t, exp_h);
    end
  endtask

  task automatic train(logic [29:0] a, logic t);
    @(negedge clk);
    tr_en = 1'b1; tr_addr = a; tr_taken = t;
    @(negedge clk);
    tr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", 30'h10, 1'b0, 1'b0);
    check("R1", 30'h3F, 1'b0, 1'b0);
  endtask

  task automatic t_alloc;
    train(30'h10, 1'b1);
    check("R8", 30'h10, 1'b1, 1'b1);
  endtask

  task automatic t_alias_evict;
    check("R4", 30'h50, 1'b1, 1'b0);
    train(30'h50, 1'b0);
    check("R8", 30'h50, 1'b0, 1'b1);
    check("R3", 30'h10, 1'b0, 1'b0);
    check("R5", 30'h90, 1'b0, 1'b0);
  endtask

  task automatic t_saturate;
    train(30'h23, 1'b1);
    train(30'h23, 1'b1);
    train(30'h23, 1'b1);
    train(30'h23, 1'b0);
    check("R6", 30'h23, 1'b1, 1'b1);
    train(30'h23, 1'b0);
    check("R6", 30'h23, 1'b0, 1'b1);
    check("R7", 30'h63, 1'b1, 1'b0);
    train(30'h05, 1'b0);
    train(30'h05, 1'b0);
    train(30'h05, 1'b1);
    check("R6", 30'h05, 1'b0, 1'b1);
    train(30'h05, 1'b1);
    check("R2", 30'h05, 1'b1, 1'b1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    tr_en = 1'b1; tr_addr = 30'h07; tr_taken = 1'b1;
    check("R9", 30'h07, 1'b0, 1'b0);
    @(negedge clk);
    tr_en = 1'b0;
    check("R9", 30'h07, 1'b1, 1'b1);
  endtask

  task automatic t_split_base;
    train(30'h15, 1'b1);
    train(30'h35, 1'b0);
    check("R4", 30'h15, 1'b1, 1'b0);
    check("R8", 30'h35, 1'b0, 1'b1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    tr_addr = 30'h35; tr_taken = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", 30'h35, 1'b0, 1'b1);
    check("R10", 30'h2A, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_alias_evict();
    t_saturate();
    t_same_cycle();
    t_split_base();
    t_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule